// File: doc/BRIEF.md
# Rearmable Watchdog Timer

This block supervises software liveness. Software stores a timeout count in a preset register and then arms the timer through a self-clearing rearm bit in a control register. While armed, the grant output stays high and an internal counter steps down by one on every clock. Software keeps the grant alive by rewriting the preset before the counter runs out; each such write reloads the counter.

When the counter reaches zero, grant falls and a one-cycle timeout pulse is issued. The block then latches in the expired state. Neither the passage of time nor further preset writes revive it; only another rearm does. A status register reports the grant state. A read-only register returns the base clock frequency, which is fixed at build time by a parameter.

Top module: `wdog_timer`

## Requirements
- R1: After synchronous reset, granted and timeout_pulse are 0, the counter reads 0, and status reads 0.
- R2: A write of 1 to bit 0 of the control register (address 3) with a nonzero stored preset sets granted to 1 from the next cycle and loads the counter with the preset. This also applies while the timer is already granted. A control write with bit 0 clear has no effect.
- R3: While granted and not written, the counter decreases by one per clock. With preset N and no further writes, granted stays high for exactly N cycles after the rearm edge.
- R4: On the clock edge where the counter reaches zero, granted falls and timeout_pulse is high for exactly that one cycle.
- R5: After a timeout, granted stays 0 and the counter stays 0 until a rearm with a nonzero preset.
- R6: A write to the counter register (address 1) always stores the preset. While granted, it also reloads the counter at the next edge. While expired, it leaves the counter and grant unchanged.
- R7: A rearm while the stored preset is zero is ignored, and the timer stays expired.
- R8: A read (rd_en) returns data with rd_valid one cycle later. Address 0 returns BASE_CLK_HZ. Address 1 returns the live counter. Address 2 returns granted in bit 0 with all other bits 0. Address 3 reads as 0.
- R9: A counter write of zero while granted expires the timer at the next edge: granted goes to 0 and timeout_pulse goes to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Register read address |
| rd_data | output | DATA_W | Registered read data |
| rd_valid | output | 1 | rd_data holds the result of the previous read |
| granted | output | 1 | High while the watchdog is running |
| timeout_pulse | output | 1 | One-cycle pulse on expiry |

## Verification
A counter that is off by one shows up directly at the ports: grant falls one cycle early or late relative to the rearm edge. A read of the live count issued the cycle after rearm also shows it at once. A grant latch that fails to hold shows as granted rising without a rearm. A reload applied while expired shows as a nonzero count readback on the very next read. Dropping the zero-preset guard makes granted rise after a rearm with no preset stored, one cycle after the control write.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int unsigned REG_ADDR_W = 2;

  // Register addresses; the bench and software rely on these values.
  typedef enum logic [REG_ADDR_W-1:0] {
    REG_CLKHZ  = 2'd0,
    REG_COUNT  = 2'd1,
    REG_STATUS = 2'd2,
    REG_CTRL   = 2'd3
  } wdog_reg_e;

  localparam int unsigned CTRL_REARM_BIT  = 0;
  localparam int unsigned STATUS_GRANT_BIT = 0;

  // Decoded write commands handed from the register front end to the core.
  typedef struct packed {
    logic load;   // counter register written
    logic rearm;  // rearm bit written as 1
  } wdog_cmd_t;

endpackage

// File: rtl/wdog_wr_decode.sv
module wdog_wr_decode
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32   // must not exceed DATA_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  output wdog_cmd_t             cmd,
  output logic [CNT_W-1:0]      load_val,
  output logic [CNT_W-1:0]      preset_q
);

  always_comb begin
    cmd.load  = wr_en && (wr_addr == REG_COUNT);
    cmd.rearm = wr_en && (wr_addr == REG_CTRL) && wr_data[CTRL_REARM_BIT];
    load_val  = wr_data[CNT_W-1:0];
  end

  // The preset is stored on every counter write, whatever the grant state.
  always_ff @(posedge clk) begin
    if (rst) begin
      preset_q <= '0;
    end else if (cmd.load) begin
      preset_q <= load_val;
    end
  end

endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  wdog_cmd_t        cmd,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] preset_q,
  output logic [CNT_W-1:0] count_q,
  output logic             grant_q,
  output logic             pulse_q
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic rearm_ok;
  logic last_tick;

  always_comb begin
    rearm_ok  = cmd.rearm && (preset_q != '0);
    last_tick = (count_q == ONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      grant_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (rearm_ok) begin
        count_q <= preset_q;
        grant_q <= 1'b1;
      end else if (cmd.load && grant_q) begin
        if (load_val == '0) begin
          count_q <= '0;
          grant_q <= 1'b0;
          pulse_q <= 1'b1;
        end else begin
          count_q <= load_val;
        end
      end else if (grant_q) begin
        if (last_tick) begin
          count_q <= '0;
          grant_q <= 1'b0;
          pulse_q <= 1'b1;
        end else begin
          count_q <= count_q - ONE;
        end
      end
    end
  end

endmodule

// File: rtl/wdog_rd_mux.sv
module wdog_rd_mux
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned BASE_CLK_HZ = 50_000_000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_en,
  input  logic [REG_ADDR_W-1:0] rd_addr,
  input  logic [CNT_W-1:0]      count_q,
  input  logic                  grant_q,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  rd_valid
);

  localparam logic [DATA_W-1:0] CLK_WORD = DATA_W'(BASE_CLK_HZ);

  logic [DATA_W-1:0] sel_word;

  always_comb begin
    sel_word = '0;
    case (rd_addr)
      REG_CLKHZ:  sel_word = CLK_WORD;
      REG_COUNT:  sel_word = DATA_W'(count_q);
      REG_STATUS: sel_word[STATUS_GRANT_BIT] = grant_q;
      default:    sel_word = '0;  // rearm bit is self-clearing
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_data <= sel_word;
      end
    end
  end

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned BASE_CLK_HZ = 50_000_000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  rd_en,
  input  logic [REG_ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  rd_valid,
  output logic                  granted,
  output logic                  timeout_pulse
);

  wdog_cmd_t        cmd;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] preset_q;
  logic [CNT_W-1:0] count_q;
  logic             grant_q;
  logic             pulse_q;

  wdog_wr_decode #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_wr (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .cmd      (cmd),
    .load_val (load_val),
    .preset_q (preset_q)
  );

  wdog_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .load_val (load_val),
    .preset_q (preset_q),
    .count_q  (count_q),
    .grant_q  (grant_q),
    .pulse_q  (pulse_q)
  );

  wdog_rd_mux #(.DATA_W(DATA_W), .CNT_W(CNT_W), .BASE_CLK_HZ(BASE_CLK_HZ)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .count_q  (count_q),
    .grant_q  (grant_q),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  assign granted       = grant_q;
  assign timeout_pulse = pulse_q;

endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wr_en,
  input logic [REG_ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0]     wr_data,
  input logic                  granted,
  input logic                  timeout_pulse,
  input logic [CNT_W-1:0]      count_q,
  input logic [CNT_W-1:0]      preset_q
);

  logic rearm_w;
  logic load_w;
  assign rearm_w = wr_en && (wr_addr == REG_CTRL) && wr_data[CTRL_REARM_BIT];
  assign load_w  = wr_en && (wr_addr == REG_COUNT);

  assert_rearm_loads_R2: assert property (@(posedge clk) disable iff (rst)
    (rearm_w && preset_q != '0) |=> (granted && count_q == $past(preset_q)));

  assert_count_steps_R3: assert property (@(posedge clk) disable iff (rst)
    (granted && !wr_en && count_q > CNT_W'(1)) |=> (granted && count_q == $past(count_q) - CNT_W'(1)));

  assert_grant_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    granted |-> (count_q != '0));

  assert_fall_pulses_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(granted) |-> timeout_pulse);

  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (rst)
    timeout_pulse |=> !timeout_pulse);

  assert_expired_latch_R5: assert property (@(posedge clk) disable iff (rst)
    (!granted && !rearm_w) |=> (!granted && count_q == '0));

  assert_reload_live_R6: assert property (@(posedge clk) disable iff (rst)
    (granted && load_w && wr_data[CNT_W-1:0] != '0) |=> (granted && count_q == $past(wr_data[CNT_W-1:0])));

  assert_load_expired_R6: assert property (@(posedge clk) disable iff (rst)
    (!granted && load_w) |=> $stable(count_q));

  assert_zero_preset_R7: assert property (@(posedge clk) disable iff (rst)
    (!granted && rearm_w && preset_q == '0) |=> !granted);

  assert_zero_write_R9: assert property (@(posedge clk) disable iff (rst)
    (granted && load_w && wr_data[CNT_W-1:0] == '0) |=> (!granted && timeout_pulse));

endmodule

bind wdog_timer wdog_timer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .wr_en         (wr_en),
  .wr_addr       (wr_addr),
  .wr_data       (wr_data),
  .granted       (granted),
  .timeout_pulse (timeout_pulse),
  .count_q       (count_q),
  .preset_q      (preset_q)
);

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;

  localparam int CLK_PERIOD = 10;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CNT_W  = 32;
  localparam int unsigned BASE_HZ = 25_000_000;
  localparam int WATCHDOG_CYCLES = 20000;

  localparam logic [1:0] A_CLK = 2'd0;
  localparam logic [1:0] A_CNT = 2'd1;
  localparam logic [1:0] A_STS = 2'd2;
  localparam logic [1:0] A_CTL = 2'd3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [1:0]        wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              rd_en = 1'b0;
  logic [1:0]        rd_addr = '0;
  logic [DATA_W-1:0] rd_data;
  logic              rd_valid;
  logic              granted;
  logic              timeout_pulse;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [DATA_W-1:0] exp_q[$];
  string             tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_timer #(.DATA_W(DATA_W), .CNT_W(CNT_W), .BASE_CLK_HZ(BASE_HZ)) dut (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .rd_en         (rd_en),
    .rd_addr       (rd_addr),
    .rd_data       (rd_data),
    .rd_valid      (rd_valid),
    .granted       (granted),
    .timeout_pulse (timeout_pulse)
  );

  task automatic check(input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver tasks start and end at a falling edge.
  task automatic reg_write(input logic [1:0] a, input logic [DATA_W-1:0] d);
    wr_addr = a;
    wr_data = d;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, input logic [DATA_W-1:0] exp, input string tag);
    rd_addr = a;
    rd_en   = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en   = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: pops expected read data as results appear.
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_checks++;
        n_fail++;
        $display("FAIL R8: actual unexpected read %0h expected no read", rd_data);
      end else begin
        check(rd_data, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(DATA_W'(granted), 1'b0, "R1 granted");
    check(DATA_W'(timeout_pulse), 1'b0, "R1 pulse");
    reg_read(A_CNT, 0, "R1 count");
    reg_read(A_STS, 0, "R1 status");
    reg_read(A_CLK, BASE_HZ, "R8 clock word");
    reg_read(A_CTL, 0, "R8 ctrl reads zero");

    // R7 rearm with no preset
    reg_write(A_CTL, 1);
    check(DATA_W'(granted), 1'b0, "R7 zero preset rearm");

    // R6 preset write while expired
    reg_write(A_CNT, 5);
    reg_read(A_CNT, 0, "R6 expired load keeps count");
    check(DATA_W'(granted), 1'b0, "R6 expired load no grant");

    // R2 control write with bit 0 clear
    reg_write(A_CTL, 32'hFFFF_FFFE);
    check(DATA_W'(granted), 1'b0, "R2 bit0 clear ignored");

    // R2/R3/R4 full run with N=5
    reg_write(A_CTL, 1);                   // count 5
    check(DATA_W'(granted), 1'b1, "R2 granted");
    reg_read(A_CNT, 5, "R2 count loaded");  // now 4
    reg_read(A_STS, 1, "R8 status granted"); // now 3
    idle(2);                                // now 1
    check(DATA_W'(granted), 1'b1, "R3 still granted");
    check(DATA_W'(timeout_pulse), 1'b0, "R4 no early pulse");
    idle(1);
    check(DATA_W'(granted), 1'b0, "R4 grant fell");
    check(DATA_W'(timeout_pulse), 1'b1, "R4 pulse");
    idle(1);
    check(DATA_W'(timeout_pulse), 1'b0, "R4 pulse one cycle");

    // R5 latched
    idle(10);
    check(DATA_W'(granted), 1'b0, "R5 stays expired");
    reg_read(A_CNT, 0, "R5 count zero");
    reg_read(A_STS, 0, "R8 status expired");

    // R6 kick while running
    reg_write(A_CTL, 1);                    // 5
    idle(2);                                // 3
    reg_write(A_CNT, 7);                    // 7
    reg_read(A_CNT, 7, "R6 reload");        // 6
    idle(5);                                // 1
    check(DATA_W'(granted), 1'b1, "R6 kick extended");
    idle(1);
    check(DATA_W'(granted), 1'b0, "R4 expire after kick");
    check(DATA_W'(timeout_pulse), 1'b1, "R4 pulse after kick");

    // R6 last-moment kick, then R9 zero write
    reg_write(A_CNT, 4);
    reg_write(A_CTL, 1);                    // 4
    idle(3);                                // 1
    reg_write(A_CNT, 4);                    // 4
    check(DATA_W'(granted), 1'b1, "R6 kick on last cycle");
    check(DATA_W'(timeout_pulse), 1'b0, "R6 no pulse on kick");
    reg_write(A_CNT, 0);
    check(DATA_W'(granted), 1'b0, "R9 zero write expires");
    check(DATA_W'(timeout_pulse), 1'b1, "R9 zero write pulse");
    idle(1);

    // R7 preset now zero
    reg_write(A_CTL, 1);
    check(DATA_W'(granted), 1'b0, "R7 rearm refused");
    reg_read(A_CNT, 0, "R7 count zero");

    // R2 rearm while running reloads
    reg_write(A_CNT, 3);
    reg_write(A_CTL, 1);                    // 3
    idle(1);                                // 2
    reg_write(A_CTL, 1);                    // 3
    reg_read(A_CNT, 3, "R2 rearm reloads"); // 2
    idle(1);                                // 1
    check(DATA_W'(granted), 1'b1, "R3 before expiry");
    idle(1);
    check(DATA_W'(granted), 1'b0, "R4 expiry after rearm");

    idle(2);
    check(DATA_W'(exp_q.size()), 0, "R8 all reads returned");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule